// File: doc/BRIEF.md
# QPSK Integrate-and-Dump Demodulator

This block turns digitized QPSK correlator inputs back into a serial bit stream. Upstream logic supplies two signed sample streams: the received signal already multiplied by the in-phase reference and by the quadrature reference. A shared qualifier marks the cycles that carry a sample. Each channel sums its own products over one symbol. A fixed timer counts qualified samples and ends the symbol after a set number of them. At that boundary it reads both sums, decides a bit for each from the sign, and clears both sums so that the next symbol starts from zero.

The two decisions of a symbol are then serialized. The in-phase bit comes out first and the quadrature bit second, which restores the alternating order of the original bit stream. Each output bit carries a one-cycle valid strobe. Symbol timing is free-running from reset. Carrier and timing recovery, mixing and filtering are left to the surrounding logic.

Top module: `qpsk_iad_demod`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) holds `bit_vld` low in the following cycle and clears both sums and the sample counter. Samples of a partly received symbol before reset never affect any later decision.
- R2: A symbol ends at the edge that accepts its SPS-th qualified sample (default SPS = 8). Only cycles with `smp_vld` high count toward the SPS.
- R3: The sums never wrap. A symbol of SPS samples at -2^(SW-1) decides 0, and a symbol of SPS samples at 2^(SW-1)-1 decides 1 (default SW = 8).
- R4: A channel's decision is 1 when its symbol sum is strictly greater than zero. It is 0 when the sum is zero or negative.
- R5: Both sums are cleared at every symbol boundary, so each decision depends only on that symbol's own samples.
- R6: The in-phase decision appears on `bit_out` with `bit_vld` high in the cycle that follows the edge accepting the symbol's last sample. The quadrature decision follows in the next cycle.
- R7: `bit_vld` is high in exactly two cycles per symbol, those given in R6, and low at all other times.
- R8: Sample values presented while `smp_vld` is low have no effect on any decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Marks a cycle that carries a sample on both product inputs |
| i_prod | input | SW | Signed received signal times the in-phase reference |
| q_prod | input | SW | Signed received signal times the quadrature reference |
| bit_out | output | 1 | Recovered serial bit |
| bit_vld | output | 1 | One-cycle strobe qualifying `bit_out` |

## Verification
When the edge that accepts a symbol's last sample is edge c, the in-phase bit is due in the cycle after c. The quadrature bit is due one cycle later. No other cycle should carry a strobe. The driver records the cycle number at which it presents each final sample, and queues the two expected bits with due cycles c+1 and c+2. The monitor samples on the falling edge. It checks both the bit value and the current cycle against the queue head, and it flags any strobe that arrives while the queue is empty.

// File: rtl/qpsk_iad_pkg.sv
package qpsk_iad_pkg;

   // Sum width: sample width plus growth over SPS terms plus one guard bit.
   function automatic int sum_width(input int smp_w, input int sps);
      return smp_w + $clog2(sps) + 1;
   endfunction

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_QUAD = 1'b1
   } ser_phase_e;

endpackage

// File: rtl/symbol_timer.sv
module symbol_timer #(
   parameter int SPS = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic smp_vld,
   output logic dump
);
   localparam int CNT_W = (SPS > 1) ? $clog2(SPS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SPS - 1);
   localparam bit POW2 = (SPS == (1 << CNT_W));

   logic [CNT_W-1:0] cnt;

   assign dump = smp_vld && (cnt == LAST);

   generate
      if (POW2) begin : g_wrap
         // Natural wrap of the counter marks the boundary.
         always_ff @(posedge clk) begin
            if (rst)          cnt <= '0;
            else if (smp_vld) cnt <= cnt + 1'b1;
         end
      end else begin : g_cmp
         always_ff @(posedge clk) begin
            if (rst)          cnt <= '0;
            else if (smp_vld) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
         end
      end
   endgenerate

   // Two boundaries can never be adjacent while SPS is at least 2.
   assert_dump_spacing_R2: assert property (@(posedge clk) disable iff (rst)
      dump |=> !dump);

   assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
      cnt <= LAST);

endmodule

// File: rtl/iad_channel.sv
module iad_channel #(
   parameter int SW    = 8,
   parameter int SPS   = 8,
   parameter int ACC_W = 12
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 smp_vld,
   input  logic                 dump,
   input  logic signed [SW-1:0] smp,
   output logic                 dec_now,
   output logic                 dec_held
);
   localparam int ACC_HI = SPS * ((1 << (SW - 1)) - 1);
   localparam int ACC_LO = -SPS * (1 << (SW - 1));

   logic signed [ACC_W-1:0] acc;
   logic signed [ACC_W-1:0] smp_ext;
   logic signed [ACC_W-1:0] sum_next;

   assign smp_ext  = {{(ACC_W - SW){smp[SW-1]}}, smp};
   assign sum_next = acc + smp_ext;
   // Strictly positive decides 1; zero and negative decide 0.
   assign dec_now  = !sum_next[ACC_W-1] && (sum_next != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         acc      <= '0;
         dec_held <= 1'b0;
      end else if (smp_vld) begin
         if (dump) begin
            acc      <= '0;
            dec_held <= dec_now;
         end else begin
            acc <= sum_next;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst) begin
         assert_acc_range_R3: assert (int'(acc) <= ACC_HI && int'(acc) >= ACC_LO);
      end
   end

   assert_dump_clears_R5: assert property (@(posedge clk) disable iff (rst)
      dump |=> (acc == '0));

endmodule

// File: rtl/bit_serializer.sv
module bit_serializer
   import qpsk_iad_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic load,
   input  logic first_bit,
   input  logic second_bit,
   output logic bit_out,
   output logic bit_vld
);
   ser_phase_e ph;

   always_ff @(posedge clk) begin
      if (rst) begin
         ph      <= PH_IDLE;
         bit_out <= 1'b0;
         bit_vld <= 1'b0;
      end else if (load) begin
         ph      <= PH_QUAD;
         bit_out <= first_bit;
         bit_vld <= 1'b1;
      end else if (ph == PH_QUAD) begin
         ph      <= PH_IDLE;
         bit_out <= second_bit;
         bit_vld <= 1'b1;
      end else begin
         bit_vld <= 1'b0;
      end
   end

   assert_first_bit_R6: assert property (@(posedge clk) disable iff (rst)
      load |=> bit_vld);

   assert_second_bit_R6: assert property (@(posedge clk) disable iff (rst)
      load |=> ##1 bit_vld);

   assert_strobe_pair_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(bit_vld) |=> bit_vld);

endmodule

// File: rtl/qpsk_iad_demod.sv
module qpsk_iad_demod
   import qpsk_iad_pkg::*;
#(
   parameter int SW  = 8,
   parameter int SPS = 8
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 smp_vld,
   input  logic signed [SW-1:0] i_prod,
   input  logic signed [SW-1:0] q_prod,
   output logic                 bit_out,
   output logic                 bit_vld
);
   localparam int ACC_W = sum_width(SW, SPS);
   localparam int NCH   = 2;

   generate
      if (SPS < 2) begin : g_bad_sps
         $error("SPS must be at least 2 so the two output bits fit in one symbol");
      end
      if (SW < 2) begin : g_bad_sw
         $error("SW must be at least 2");
      end
      if (ACC_W > 32) begin : g_bad_accw
         $error("sum width exceeds 32 bits");
      end
   endgenerate

   logic                 dump;
   logic signed [SW-1:0] ch_smp   [NCH];
   logic                 dec_now  [NCH];
   logic                 dec_held [NCH];

   assign ch_smp[0] = i_prod;
   assign ch_smp[1] = q_prod;

   symbol_timer #(.SPS(SPS)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .smp_vld (smp_vld),
      .dump    (dump)
   );

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      iad_channel #(.SW(SW), .SPS(SPS), .ACC_W(ACC_W)) u_ch (
         .clk      (clk),
         .rst      (rst),
         .smp_vld  (smp_vld),
         .dump     (dump),
         .smp      (ch_smp[ch]),
         .dec_now  (dec_now[ch]),
         .dec_held (dec_held[ch])
      );
   end

   // In-phase decision leaves at the boundary; quadrature comes from its hold register.
   bit_serializer u_ser (
      .clk        (clk),
      .rst        (rst),
      .load       (dump),
      .first_bit  (dec_now[0]),
      .second_bit (dec_held[1]),
      .bit_out    (bit_out),
      .bit_vld    (bit_vld)
   );

endmodule

// File: tb/sim_qpsk_iad_demod.sv
`timescale 1ns/1ps
module sim_qpsk_iad_demod;
   localparam int SW  = 8;
   localparam int SPS = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic smp_vld = 1'b0;
   logic signed [SW-1:0] i_prod = '0;
   logic signed [SW-1:0] q_prod = '0;
   logic bit_out;
   logic bit_vld;

   qpsk_iad_demod #(.SW(SW), .SPS(SPS)) u0 (
      .clk(clk), .rst(rst), .smp_vld(smp_vld),
      .i_prod(i_prod), .q_prod(q_prod),
      .bit_out(bit_out), .bit_vld(bit_vld)
   );

   always #2.5 clk = ~clk;

   typedef struct {
      logic  b;
      int    due;
      string tag;
   } exp_t;

   exp_t sb[$];
   int cyc = 0;
   int checks = 0;
   int errors = 0;
   int ia[SPS];
   int qa[SPS];

   always @(posedge clk) cyc <= cyc + 1;

   // Monitor: compare every strobe with the queue head, both value and cycle.
   always @(negedge clk) begin
      if (!rst && bit_vld) begin
         checks++;
         if (sb.size() == 0) begin
            errors++;
            $display("FAIL R7: strobe at cycle %0d with bit %0b, expected no strobe", cyc, bit_out);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (bit_out !== e.b || cyc != e.due) begin
               errors++;
               $display("FAIL %s: bit %0b at cycle %0d, expected bit %0b at cycle %0d",
                        e.tag, bit_out, cyc, e.b, e.due);
            end
         end
      end
   end

   task automatic put(input int iv, input int qv);
      i_prod  = SW'(iv);
      q_prod  = SW'(qv);
      smp_vld = 1'b1;
      @(posedge clk); #1;
      smp_vld = 1'b0;
   endtask

   // Idle cycles carry large values that would flip decisions if integrated (R8).
   task automatic idle(input int n);
      smp_vld = 1'b0;
      i_prod  = 8'sd127;
      q_prod  = -8'sd128;
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic symbol(input int gap, input string tag);
      int si = 0;
      int sq = 0;
      for (int k = 0; k < SPS; k++) begin
         si += ia[k];
         sq += qa[k];
      end
      for (int k = 0; k < SPS; k++) begin
         if (gap > 0 && (k % 3) == 1) idle(gap);
         if (k == SPS - 1) begin
            sb.push_back('{b: (si > 0), due: cyc + 1, tag: tag});
            sb.push_back('{b: (sq > 0), due: cyc + 2, tag: tag});
         end
         put(ia[k], qa[k]);
      end
   endtask

   task automatic fill(input int iv, input int qv);
      for (int k = 0; k < SPS; k++) begin ia[k] = iv; qa[k] = qv; end
   endtask

   task automatic check_quiet(input string tag);
      @(negedge clk);
      checks++;
      if (bit_vld !== 1'b0) begin
         errors++;
         $display("FAIL %s: bit_vld %0b, expected 0", tag, bit_vld);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check_quiet("R1");
      @(posedge clk); #1;
      rst = 1'b0;

      // R6 order: in-phase first, quadrature second.
      fill(5, -5);              symbol(0, "R6");
      fill(-1, 1);              symbol(0, "R4");
      // R4 zero sum decides 0; a sum of +1 decides 1.
      fill(0, 0);
      for (int k = 0; k < SPS; k++) ia[k] = (k % 2 == 0) ? 3 : -3;
      qa[5] = 1;                symbol(0, "R4");
      // R3 full-scale symbols.
      fill(-128, 127);          symbol(0, "R3");
      fill(127, -128);          symbol(0, "R3");
      // R5 a symbol after a full-scale one is judged on its own samples.
      fill(0, 0); ia[2] = -1; qa[6] = 1;
      symbol(0, "R5");
      // R8 / R2 gaps with garbage between qualified samples.
      for (int k = 0; k < SPS; k++) begin
         ia[k] = (k % 2 == 0) ? 2 : -3;
         qa[k] = 1;
      end
      symbol(2, "R8");
      for (int k = 0; k < SPS; k++) begin
         ia[k] = -1;
         qa[k] = (k == 0) ? 9 : -1;
      end
      symbol(1, "R2");
      // R2 / R7 back-to-back symbols.
      for (int s = 0; s < 4; s++) begin
         fill((s % 2 == 1) ? 4 : -4, (s > 1) ? 1 : -1);
         symbol(0, "R7");
      end
      idle(4);

      // R1 reset in mid-symbol discards the partial sums.
      for (int k = 0; k < 4; k++) put(100, -100);
      rst = 1'b1;
      @(posedge clk); #1;
      check_quiet("R1");
      @(posedge clk); #1;
      rst = 1'b0;
      fill(0, 0); ia[0] = -1; qa[3] = 1;
      symbol(0, "R1");
      idle(6);

      checks++;
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL R7: %0d expected bits never strobed, expected 0", sb.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      checks++;
      errors++;
      $display("FAIL watchdog: run still active at cycle %0d, expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule